// File: doc/BRIEF.md
# Ethernet Receive Frame Statistics Counters

This block sits beside the receive side of an Ethernet MAC. It keeps a bank of thirteen management counters. Once per received frame the MAC gives a single-cycle status strobe with these fields:

- the frame length in bytes, counted without preamble;
- good/bad status;
- unicast, VLAN-tag and valid-pause flags;
- the value of the length/type field;
- a flag saying the frame was lost to a full receive FIFO;
- a flag saying the receive watchdog cut the frame off.

The block sorts the frame into length bins and error classes. It then bumps every matching counter in the same cycle.

Software reads the counters through a word-addressed read port at fixed byte offsets. Read data appears one cycle after the request. Each counter holds at all-ones instead of wrapping. A read that lands in the same cycle as an increment of the same counter returns the older value. The increment still takes effect.

Top module: `rxstat_counter_bank`

## Requirements
- R1: After reset, every counter reads zero. Each counter is CNT_W bits wide (32 by default) and is returned zero-extended on the 32-bit read data.
- R2: Every frame that was not dropped goes into at most one length bin, good or bad, based on its length. The bins are exactly 64, 65–127, 128–255, 256–511, 512–1023, and 1024 up to MAX_LEN (default 1518). Lengths below 64 or above MAX_LEN touch no bin. One strobe may bump several counters in the same cycle.
- R3: The unicast counter increments only for frames flagged both good and unicast.
- R4: The length-error counter increments when the length/type field is 1500 or less and differs from the payload size. Payload size is the frame length minus 18, minus a further 4 for a VLAN-tagged frame. There is one exception: a 64-byte frame whose field is smaller than the payload size is padded, not in error.
- R5: The out-of-range counter increments when the length/type field is from 1501 to 1535 inclusive.
- R6: The pause counter increments only for frames that are both good and flagged as valid pause frames.
- R7: A frame flagged as lost to FIFO overflow increments the overflow counter by one and no other counter.
- R8: The VLAN counter increments for every tagged frame that was not dropped, good or bad.
- R9: The watchdog counter increments for every frame flagged as cut off by the receive watchdog.
- R10: Counter k sits at byte offset 0x1AC + 4k. The counters are, in this order: the six length bins from shortest to longest, unicast, length error, out-of-range, pause, overflow, VLAN, watchdog. Address bits [1:0] are ignored. rd_data takes the value one clock after rd_en is sampled high, and holds it while rd_en is low.
- R11: The reserved offsets 0x1E0–0x1FC, and every other address that maps to no counter, read zero.
- R12: A counter at all-ones stays at all-ones when further increments arrive.
- R13: A read of a counter in the cycle it is incremented returns the value from before the increment, and the increment is not lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Per-frame status strobe, one cycle |
| st_len | input | 16 | Frame length in bytes, preamble excluded |
| st_good | input | 1 | Frame received without error |
| st_unicast | input | 1 | Destination is a unicast address |
| st_vlan | input | 1 | Frame carries a VLAN tag |
| st_pause_ok | input | 1 | Frame is a valid pause frame |
| st_lentype | input | 16 | Value of the length/type field |
| st_fifo_drop | input | 1 | Frame lost because the receive FIFO was full |
| st_wdog_cut | input | 1 | Frame truncated by the receive watchdog |
| rd_en | input | 1 | Read request |
| rd_addr | input | 12 | Byte address of the read |
| rd_data | output | 32 | Read data, registered |

## Verification
Random frames are drawn from lengths sitting on and next to every bin edge (63, 64, 65, 127, 128, … MAX_LEN, MAX_LEN+1), so an off-by-one at any edge moves a count into the wrong bin. Length/type values are drawn from the true payload size, payload size ±1, small padded values, 1500, 1501, 1535, 1536 and type codes. This separates the length-error rule, the padding exception and the out-of-range window. Random good, unicast, VLAN, pause, drop and watchdog flags show whether the qualifiers are combined with the right polarity, and whether a dropped frame leaks into other counters.

Directed cases cover three further points:
- Address aliasing through the low bits, and reads of reserved offsets.
- A read colliding with an increment, which tells a pre-increment value from a post-increment one.
- A narrow-counter copy driven past its limit, which tells saturation from wrap-around.

// File: rtl/rxstat_pkg.sv
package rxstat_pkg;

   // Number of counters and their word positions in the map (the order is fixed).
   localparam int NUM_CNT   = 13;
   localparam int NUM_BINS  = 6;
   localparam int C_BIN0    = 0;
   localparam int C_UNICAST = 6;
   localparam int C_LENERR  = 7;
   localparam int C_RANGE   = 8;
   localparam int C_PAUSE   = 9;
   localparam int C_OVFL    = 10;
   localparam int C_VLAN    = 11;
   localparam int C_WDOG    = 12;

   // Bin edges that do not depend on the configured maximum.
   localparam int BIN_EDGE_65   = 65;
   localparam int BIN_EDGE_128  = 128;
   localparam int BIN_EDGE_256  = 256;
   localparam int BIN_EDGE_512  = 512;
   localparam int BIN_EDGE_1024 = 1024;

endpackage

// File: rtl/rxstat_classify.sv
module rxstat_classify
   import rxstat_pkg::*;
#(
   parameter int LEN_W         = 16,
   parameter int MAX_LEN       = 1518,
   parameter int MIN_FRAME     = 64,
   parameter int HDR_BYTES     = 14,
   parameter int FCS_BYTES     = 4,
   parameter int TAG_BYTES     = 4,
   parameter int LEN_FIELD_MAX = 1500,
   parameter int TYPE_MIN      = 1536
)(
   input  logic             st_valid,
   input  logic [LEN_W-1:0] st_len,
   input  logic             st_good,
   input  logic             st_unicast,
   input  logic             st_vlan,
   input  logic             st_pause_ok,
   input  logic [LEN_W-1:0] st_lentype,
   input  logic             st_fifo_drop,
   input  logic             st_wdog_cut,
   output logic [NUM_CNT-1:0] inc
);

   localparam int BIN_LO [NUM_BINS] = '{MIN_FRAME, BIN_EDGE_65, BIN_EDGE_128,
                                        BIN_EDGE_256, BIN_EDGE_512, BIN_EDGE_1024};
   localparam int BIN_HI [NUM_BINS] = '{MIN_FRAME, BIN_EDGE_128 - 1, BIN_EDGE_256 - 1,
                                        BIN_EDGE_512 - 1, BIN_EDGE_1024 - 1, MAX_LEN};

   localparam logic [LEN_W-1:0] OVH_PLAIN = LEN_W'(HDR_BYTES + FCS_BYTES);
   localparam logic [LEN_W-1:0] OVH_TAG   = LEN_W'(HDR_BYTES + FCS_BYTES + TAG_BYTES);
   localparam logic [LEN_W-1:0] L_MIN     = LEN_W'(MIN_FRAME);
   localparam logic [LEN_W-1:0] L_FLD_MAX = LEN_W'(LEN_FIELD_MAX);
   localparam logic [LEN_W-1:0] L_TYPE    = LEN_W'(TYPE_MIN);

   logic                live;
   logic [NUM_BINS-1:0] in_bin;
   logic [LEN_W-1:0]    overhead;
   logic [LEN_W-1:0]    payload;
   logic                field_is_len;
   logic                padded;
   logic                len_mismatch;
   logic                type_gap;

   // A dropped frame carries no trustworthy status: only the overflow count sees it.
   assign live = st_valid & ~st_fifo_drop;

   genvar b;
   generate
      for (b = 0; b < NUM_BINS; b++) begin : g_bin
         assign in_bin[b] = (st_len >= LEN_W'(BIN_LO[b])) && (st_len <= LEN_W'(BIN_HI[b]));
      end
   endgenerate

   assign overhead     = st_vlan ? OVH_TAG : OVH_PLAIN;
   assign payload      = (st_len >= overhead) ? (st_len - overhead) : '0;
   assign field_is_len = (st_lentype <= L_FLD_MAX);
   assign padded       = (st_len == L_MIN) && (st_lentype < payload);
   assign len_mismatch = field_is_len && (st_lentype != payload) && !padded;
   assign type_gap     = (st_lentype > L_FLD_MAX) && (st_lentype < L_TYPE);

   always_comb begin
      inc = '0;
      for (int k = 0; k < NUM_BINS; k++) begin
         inc[C_BIN0 + k] = live & in_bin[k];
      end
      inc[C_UNICAST] = live & st_good & st_unicast;
      inc[C_LENERR]  = live & len_mismatch;
      inc[C_RANGE]   = live & type_gap;
      inc[C_PAUSE]   = live & st_good & st_pause_ok;
      inc[C_OVFL]    = st_valid & st_fifo_drop;
      inc[C_VLAN]    = live & st_vlan;
      inc[C_WDOG]    = live & st_wdog_cut;
   end

endmodule

// File: rtl/rxstat_counter.sv
module rxstat_counter #(
   parameter int CNT_W    = 32,
   parameter bit SATURATE = 1'b1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bump,
   output logic [CNT_W-1:0] value
);

   localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
   localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

   generate
      if (SATURATE) begin : g_sat
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               value <= '0;
            end else if (bump && (value != FULL)) begin
               value <= value + ONE;
            end
         end
      end else begin : g_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               value <= '0;
            end else if (bump) begin
               value <= value + ONE;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/rxstat_readout.sv
module rxstat_readout #(
   parameter int                ADDR_W    = 12,
   parameter int                DATA_W    = 32,
   parameter int                CNT_W     = 32,
   parameter int                NUM       = 13,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h1AC
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      rd_en,
   input  logic [ADDR_W-1:0]         rd_addr,
   input  logic [NUM-1:0][CNT_W-1:0] cnt,
   output logic [DATA_W-1:0]         rd_data
);

   localparam int WORD_W = ADDR_W - 2;
   localparam logic [WORD_W-1:0] BASE_W = BASE_ADDR[ADDR_W-1:2];

   logic [WORD_W-1:0] word;
   logic [NUM-1:0]    hit;
   logic [CNT_W-1:0]  sel;
   logic [1:0]        unused_byte_lane;

   assign word             = rd_addr[ADDR_W-1:2];
   assign unused_byte_lane = rd_addr[1:0];

   genvar k;
   generate
      for (k = 0; k < NUM; k++) begin : g_hit
         assign hit[k] = (word == (BASE_W + WORD_W'(k)));
      end
   endgenerate

   // One-hot select: an address outside the map yields zero.
   always_comb begin
      sel = '0;
      for (int i = 0; i < NUM; i++) begin
         sel = sel | (cnt[i] & {CNT_W{hit[i]}});
      end
   end

   generate
      if (CNT_W == DATA_W) begin : g_full
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     rd_data <= '0;
            else if (rd_en) rd_data <= sel;
         end
      end else begin : g_ext
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     rd_data <= '0;
            else if (rd_en) rd_data <= {{(DATA_W-CNT_W){1'b0}}, sel};
         end
      end
   endgenerate

endmodule

// File: rtl/rxstat_counter_bank.sv
module rxstat_counter_bank
   import rxstat_pkg::*;
#(
   parameter int                CNT_W         = 32,
   parameter int                DATA_W        = 32,
   parameter int                LEN_W         = 16,
   parameter int                ADDR_W        = 12,
   parameter logic [ADDR_W-1:0] BASE_ADDR     = 12'h1AC,
   parameter int                MAX_LEN       = 1518,
   parameter int                MIN_FRAME     = 64,
   parameter int                HDR_BYTES     = 14,
   parameter int                FCS_BYTES     = 4,
   parameter int                TAG_BYTES     = 4,
   parameter int                LEN_FIELD_MAX = 1500,
   parameter int                TYPE_MIN      = 1536,
   parameter bit                SATURATE      = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              st_valid,
   input  logic [LEN_W-1:0]  st_len,
   input  logic              st_good,
   input  logic              st_unicast,
   input  logic              st_vlan,
   input  logic              st_pause_ok,
   input  logic [LEN_W-1:0]  st_lentype,
   input  logic              st_fifo_drop,
   input  logic              st_wdog_cut,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   // Elaboration-time parameter checks.
   generate
      if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt_w
         $error("rxstat_counter_bank: CNT_W must lie in 1..DATA_W");
      end
      if (BASE_ADDR[1:0] != 2'b00) begin : g_bad_base
         $error("rxstat_counter_bank: BASE_ADDR must be word aligned");
      end
      if (MAX_LEN < BIN_EDGE_1024 || MAX_LEN >= (1 << LEN_W)) begin : g_bad_max
         $error("rxstat_counter_bank: MAX_LEN out of range");
      end
      if (LEN_FIELD_MAX >= TYPE_MIN || TYPE_MIN >= (1 << LEN_W)) begin : g_bad_type
         $error("rxstat_counter_bank: length/type thresholds inconsistent");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("rxstat_counter_bank: ADDR_W too small");
      end
   endgenerate

   logic [NUM_CNT-1:0]            inc_vec;
   logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q;

   rxstat_classify #(
      .LEN_W         (LEN_W),
      .MAX_LEN       (MAX_LEN),
      .MIN_FRAME     (MIN_FRAME),
      .HDR_BYTES     (HDR_BYTES),
      .FCS_BYTES     (FCS_BYTES),
      .TAG_BYTES     (TAG_BYTES),
      .LEN_FIELD_MAX (LEN_FIELD_MAX),
      .TYPE_MIN      (TYPE_MIN)
   ) u_classify (
      .st_valid     (st_valid),
      .st_len       (st_len),
      .st_good      (st_good),
      .st_unicast   (st_unicast),
      .st_vlan      (st_vlan),
      .st_pause_ok  (st_pause_ok),
      .st_lentype   (st_lentype),
      .st_fifo_drop (st_fifo_drop),
      .st_wdog_cut  (st_wdog_cut),
      .inc          (inc_vec)
   );

   genvar c;
   generate
      for (c = 0; c < NUM_CNT; c++) begin : g_cnt
         rxstat_counter #(
            .CNT_W    (CNT_W),
            .SATURATE (SATURATE)
         ) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .bump  (inc_vec[c]),
            .value (cnt_q[c])
         );
      end
   endgenerate

   rxstat_readout #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .CNT_W     (CNT_W),
      .NUM       (NUM_CNT),
      .BASE_ADDR (BASE_ADDR)
   ) u_readout (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (rd_en),
      .rd_addr (rd_addr),
      .cnt     (cnt_q),
      .rd_data (rd_data)
   );

endmodule

// File: rtl/rxstat_checker.sv
module rxstat_checker
   import rxstat_pkg::*;
#(
   parameter int                CNT_W     = 32,
   parameter int                DATA_W    = 32,
   parameter int                ADDR_W    = 12,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h1AC,
   parameter bit                SATURATE  = 1'b1
)(
   input logic                          clk,
   input logic                          rst_n,
   input logic                          st_valid,
   input logic                          st_good,
   input logic                          st_unicast,
   input logic                          st_fifo_drop,
   input logic                          st_wdog_cut,
   input logic                          rd_en,
   input logic [ADDR_W-1:0]             rd_addr,
   input logic [DATA_W-1:0]             rd_data,
   input logic [NUM_CNT-1:0]            inc,
   input logic [NUM_CNT-1:0][CNT_W-1:0] cnt
);

   localparam logic [CNT_W-1:0]  ONE    = {{(CNT_W-1){1'b0}}, 1'b1};
   localparam logic [CNT_W-1:0]  FULL   = {CNT_W{1'b1}};
   localparam int                WORD_W = ADDR_W - 2;
   localparam logic [WORD_W-1:0] LO_W   = BASE_ADDR[ADDR_W-1:2];
   localparam logic [WORD_W-1:0] HI_W   = LO_W + WORD_W'(NUM_CNT - 1);

   logic mapped;
   assign mapped = (rd_addr[ADDR_W-1:2] >= LO_W) && (rd_addr[ADDR_W-1:2] <= HI_W);

   // R1: counters are cleared while reset is held
   assert_reset_clear_R1: assert property (@(posedge clk) !rst_n |-> (cnt == '0));

   // R2: a frame lands in at most one length bin
   assert_one_bin_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(inc[C_BIN0 +: NUM_BINS]));

   // R3: unicast count needs a good unicast frame
   assert_unicast_good_R3: assert property (@(posedge clk) disable iff (!rst_n)
      inc[C_UNICAST] |-> (st_valid && st_good && st_unicast));

   // R7: a dropped frame touches only the overflow counter
   assert_drop_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && st_fifo_drop) |-> ($countones(inc) == 1 && inc[C_OVFL]));

   // R9: every truncated, kept frame reaches the watchdog counter
   assert_wdog_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && st_wdog_cut && !st_fifo_drop) |-> inc[C_WDOG]);

   // R11: unmapped addresses read back zero
   assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !mapped) |=> (rd_data == '0));

   genvar i;
   generate
      for (i = 0; i < NUM_CNT; i++) begin : g_chk
         // R13: a requested increment below the limit always lands
         assert_no_lost_inc_R13: assert property (@(posedge clk) disable iff (!rst_n)
            (inc[i] && cnt[i] != FULL) |=> (cnt[i] == $past(cnt[i]) + ONE));
         // R13: with no request the count does not move
         assert_hold_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
            !inc[i] |=> $stable(cnt[i]));
         if (SATURATE) begin : g_sat
            // R12: an all-ones counter stays there
            assert_no_overflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
               (cnt[i] == FULL) |=> (cnt[i] == FULL));
         end
      end
   endgenerate

endmodule

bind rxstat_counter_bank rxstat_checker #(
   .CNT_W     (CNT_W),
   .DATA_W    (DATA_W),
   .ADDR_W    (ADDR_W),
   .BASE_ADDR (BASE_ADDR),
   .SATURATE  (SATURATE)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .st_valid     (st_valid),
   .st_good      (st_good),
   .st_unicast   (st_unicast),
   .st_fifo_drop (st_fifo_drop),
   .st_wdog_cut  (st_wdog_cut),
   .rd_en        (rd_en),
   .rd_addr      (rd_addr),
   .rd_data      (rd_data),
   .inc          (inc_vec),
   .cnt          (cnt_q)
);

// File: tb/sim_rxstat_counter_bank.sv
`timescale 1ns/1ps
module sim_rxstat_counter_bank;

   localparam int NC     = 13;
   localparam int MAXLEN = 1518;
   localparam int SMALLW = 8;
   localparam longint SMALL_FULL = (1 << SMALLW) - 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        st_valid = 1'b0;
   logic [15:0] st_len = '0;
   logic        st_good = 1'b0;
   logic        st_unicast = 1'b0;
   logic        st_vlan = 1'b0;
   logic        st_pause_ok = 1'b0;
   logic [15:0] st_lentype = '0;
   logic        st_fifo_drop = 1'b0;
   logic        st_wdog_cut = 1'b0;
   logic        rd_en = 1'b0;
   logic [11:0] rd_addr = '0;
   logic [31:0] rd_data;
   logic [31:0] rd_data_s;

   int     n_checks = 0;
   int     n_fail   = 0;
   longint expc [NC];
   bit     done = 1'b0;

   always #2.5 clk = ~clk;

   rxstat_counter_bank u0 (
      .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_len(st_len),
      .st_good(st_good), .st_unicast(st_unicast), .st_vlan(st_vlan),
      .st_pause_ok(st_pause_ok), .st_lentype(st_lentype),
      .st_fifo_drop(st_fifo_drop), .st_wdog_cut(st_wdog_cut),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   // Narrow copy used to reach the saturation limit quickly.
   rxstat_counter_bank #(.CNT_W(SMALLW)) u1 (
      .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_len(st_len),
      .st_good(st_good), .st_unicast(st_unicast), .st_vlan(st_vlan),
      .st_pause_ok(st_pause_ok), .st_lentype(st_lentype),
      .st_fifo_drop(st_fifo_drop), .st_wdog_cut(st_wdog_cut),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data_s)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   // Expected increment pattern, from the requirements.
   function automatic bit [NC-1:0] predict(int len, bit good, bit uni, bit vlan, bit pause,
                                           int lt, bit drop, bit wd);
      bit [NC-1:0] r = '0;
      int ovh, pay;
      if (drop) begin
         r[10] = 1'b1;                                   // R7
         return r;
      end
      if (len == 64)                     r[0] = 1'b1;    // R2
      if (len >= 65 && len <= 127)       r[1] = 1'b1;
      if (len >= 128 && len <= 255)      r[2] = 1'b1;
      if (len >= 256 && len <= 511)      r[3] = 1'b1;
      if (len >= 512 && len <= 1023)     r[4] = 1'b1;
      if (len >= 1024 && len <= MAXLEN)  r[5] = 1'b1;
      r[6] = good & uni;                                 // R3
      ovh = vlan ? 22 : 18;
      pay = (len >= ovh) ? len - ovh : 0;
      if (lt <= 1500 && lt != pay && !(len == 64 && lt < pay)) r[7] = 1'b1; // R4
      if (lt > 1500 && lt < 1536)        r[8] = 1'b1;    // R5
      r[9]  = good & pause;                              // R6
      r[11] = vlan;                                      // R8
      r[12] = wd;                                        // R9
      return r;
   endfunction

   function automatic longint sat_small(longint v);
      return (v > SMALL_FULL) ? SMALL_FULL : v;
   endfunction

   task automatic drive_frame(int len, bit good, bit uni, bit vlan, bit pause,
                              int lt, bit drop, bit wd);
      st_valid = 1'b1; st_len = 16'(len); st_good = good; st_unicast = uni;
      st_vlan = vlan; st_pause_ok = pause; st_lentype = 16'(lt);
      st_fifo_drop = drop; st_wdog_cut = wd;
   endtask

   task automatic apply_expect(int len, bit good, bit uni, bit vlan, bit pause,
                               int lt, bit drop, bit wd);
      bit [NC-1:0] p = predict(len, good, uni, vlan, pause, lt, drop, wd);
      for (int k = 0; k < NC; k++) if (p[k]) expc[k]++;
   endtask

   task automatic send(int len, bit good, bit uni, bit vlan, bit pause,
                       int lt, bit drop, bit wd);
      @(negedge clk);
      drive_frame(len, good, uni, vlan, pause, lt, drop, wd);
      @(negedge clk);
      st_valid = 1'b0;
      apply_expect(len, good, uni, vlan, pause, lt, drop, wd);
   endtask

   task automatic read_word(input logic [11:0] a, output logic [31:0] d, output logic [31:0] ds);
      @(negedge clk);
      rd_en = 1'b1; rd_addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      d = rd_data; ds = rd_data_s;
   endtask

   task automatic check_all(string req);
      logic [31:0] d, ds;
      for (int k = 0; k < NC; k++) begin
         read_word(12'(12'h1AC + 4 * k), d, ds);
         check(d == 32'(expc[k]), req, d, expc[k]);
         check(ds == 32'(sat_small(expc[k])), {req, " narrow"}, ds, sat_small(expc[k]));
      end
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         check(1'b0, "watchdog", 0, 1);
         report();
      end
   end

   initial begin
      logic [31:0] d, ds;
      int lens [14] = '{63, 64, 65, 127, 128, 255, 256, 511, 512, 1023, 1024, MAXLEN, MAXLEN + 1, 2100};
      void'($urandom(32'h5A17));
      for (int k = 0; k < NC; k++) expc[k] = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state and R11 unmapped reads
      check_all("R1");
      read_word(12'h1E0, d, ds); check(d == 0, "R11", d, 0);
      read_word(12'h1FC, d, ds); check(d == 0, "R11", d, 0);
      read_word(12'h1A8, d, ds); check(d == 0, "R11", d, 0);

      // Directed classification cases
      send(64, 1, 1, 0, 0, 46, 0, 0);       // exact 64 byte, field matches
      send(64, 0, 0, 0, 0, 10, 0, 0);       // padded small field: no R4 error
      send(100, 1, 0, 0, 0, 81, 0, 0);      // field off by one: R4 error
      send(104, 0, 0, 1, 0, 82, 0, 0);      // tagged payload matches: R4 none, R8 count
      send(300, 1, 0, 0, 0, 1501, 0, 0);    // R5 lower edge
      send(300, 1, 0, 0, 0, 1535, 0, 0);    // R5 upper edge
      send(300, 1, 0, 0, 0, 1536, 0, 0);    // type value, no count
      send(64, 1, 0, 0, 1, 16'h8808, 0, 0); // R6 good pause
      send(64, 0, 0, 0, 1, 16'h8808, 0, 0); // R6 bad pause: not counted
      send(1500, 1, 1, 1, 1, 5, 1, 1);      // R7 dropped: overflow only
      send(2100, 0, 0, 0, 0, 16'h0800, 0, 1); // R9 watchdog, no bin
      send(MAXLEN, 1, 1, 0, 0, 1500, 0, 0); // R2 top bin edge, R4 field 1500
      send(MAXLEN + 1, 1, 0, 0, 0, 16'h0800, 0, 0); // above max: no bin
      check_all("R2");

      // R10: address bits [1:0] ignored
      for (int k = 0; k < NC; k++) begin
         read_word(12'(12'h1AC + 4 * k + 3), d, ds);
         check(d == 32'(expc[k]), "R10", d, expc[k]);
      end

      // Constrained random frames
      for (int f = 0; f < 400; f++) begin
         int len, lt, pay, sel;
         bit vl;
         len = lens[$urandom_range(13, 0)];
         vl  = $urandom_range(1, 0);
         pay = (len >= (vl ? 22 : 18)) ? len - (vl ? 22 : 18) : 0;
         sel = $urandom_range(7, 0);
         case (sel)
            0: lt = pay;
            1: lt = pay + 1;
            2: lt = (pay > 0) ? pay - 1 : 0;
            3: lt = $urandom_range(45, 0);
            4: lt = 1500;
            5: lt = 1501 + $urandom_range(34, 0);
            6: lt = 1536;
            default: lt = 16'h8100;
         endcase
         send(len, 1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)), vl,
              1'($urandom_range(1, 0)), lt, ($urandom_range(7, 0) == 0),
              ($urandom_range(5, 0) == 0));
         if (f % 100 == 99) check_all("R4");
      end

      // R13: read collides with an increment of the same counter
      @(negedge clk);
      drive_frame(64, 0, 0, 0, 0, 46, 0, 0);
      rd_en = 1'b1; rd_addr = 12'h1AC;
      @(negedge clk);
      st_valid = 1'b0; rd_en = 1'b0;
      check(rd_data == 32'(expc[0]), "R13", rd_data, expc[0]);
      apply_expect(64, 0, 0, 0, 0, 46, 0, 0);
      read_word(12'h1AC, d, ds);
      check(d == 32'(expc[0]), "R13", d, expc[0]);

      // R12: drive the narrow copy past its limit
      for (int f = 0; f < 270; f++) send(64, 1, 1, 0, 0, 46, 0, 0);
      check_all("R12");

      // R11 again with non-zero counters present
      read_word(12'h1E4, d, ds); check(d == 0 && ds == 0, "R11", d, 0);
      read_word(12'h000, d, ds); check(d == 0, "R11", d, 0);

      done = 1'b1;
      report();
   end

endmodule